// File: doc/BRIEF.md
# LIN Slave Routing-Register Frame Controller

This block is the digital half of a LIN slave node that owns two 8-bit routing control registers and a sticky error register. It watches the receive line for a break, locks its bit timing to the sync field that follows, and takes in the protected identifier. The identifier selects a write frame or a read frame. A write frame carries two data bytes and a checksum, and the routing registers take the new bytes only when the checksum matches. A read frame makes the node answer with the error register, both routing registers, a fixed 0xFF filler byte and a checksum.

A two-bit strap input picks one of three identifier pairs. While it answers, the node compares every bit it drives on its transmit line with what it reads back from the bus. Frames that run past their time budget are dropped and flagged. The routing registers are brought out as ports so they can drive a switch fabric directly.

Top module: `lin_reg_slave`

## Requirements
- R1: Every byte on the line is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit, all at the bit time measured from the sync field.
- R2: A header is recognised only after the line has been low for at least 10.5 nominal bit times. The sync byte 0x55 that follows is measured from its first falling edge to its fifth, a span of 8 bits, and the bit time is that span divided by 8. A span outside 7 to 9 nominal bit times sets err_flags bit 4 (0x10) and drops the frame. A shorter low pulse is ignored.
- R3: The identifier byte carries parity in bit 6, which equals id0^id1^id2^id4, and in bit 7, which equals NOT(id1^id3^id4^id5). A mismatch sets err_flags bit 1 (0x02) and drops the frame.
- R4: id_sel 2'b00 selects write identifier 0x08 and read identifier 0xE7. 2'b01 selects 0xCA and 0xE9. 2'b10 and 2'b11 select 0x9C and 0x2B. Any other identifier with correct parity is ignored: no flag is set and no register changes.
- R5: After a write identifier, the node receives two data bytes and then a checksum. When the checksum matches, route_a takes the first byte and route_b takes the second.
- R6: The checksum is the bitwise inverse of the 8-bit sum, with end-around carry, of the identifier byte and all data bytes of the frame.
- R7: A write checksum mismatch sets err_flags bit 2 (0x04) and leaves route_a and route_b unchanged.
- R8: After a read identifier, the node transmits, starting right after the identifier's stop bit and with no gaps, the error byte, then route_a, then route_b, then 0xFF, then the checksum.
- R9: While transmitting, the node samples the bus in the middle of each bit. If it differs from the driven bit, the node sets err_flags bit 3 (0x08), releases txd high and sends nothing more in that frame.
- R10: A frame must end within 1.4 times its nominal length, counted in nominal bit times from the start of the break: 89.6 bits for a write frame, and 117.6 bits once a read identifier is seen. Exceeding the limit sets err_flags bit 0 (0x01) and drops the frame.
- R11: The error flags are sticky. New errors are OR-ed in, bits 7 to 5 always read 0, and the register clears only when a read response has completed without a readback error. The error byte sent in that response is the value before the clear.
- R12: After reset, txd is high, err_flags is 0, and route_a and route_b hold their parameter reset values (0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_sel | input | 2 | Identifier-pair strap: 00 low, 01 mid, 10/11 high |
| rxd | input | 1 | Receive line from the bus transceiver |
| txd | output | 1 | Transmit line to the bus transceiver, idle high |
| route_a | output | 8 | First routing control register |
| route_b | output | 8 | Second routing control register |
| err_flags | output | 8 | Error register: bit4 sync, bit3 readback, bit2 checksum, bit1 parity, bit0 timeout |

## Verification
On every cycle, the assertions check four things. The routing registers move only in the cycle that follows a received checksum byte. A flag falls only when a read response has completed, and then all flags fall together. The frame timer never passes its limit while a frame is open. The bit time in use always lies inside the accepted sync window. The bench scenarios are the only evidence for the values themselves: which identifier each strap setting accepts, the carry-wrapped checksum, the order and contents of the read response, the effect of a forced readback collision, and whether a short low pulse or an off-rate sync is rejected.

// File: rtl/lin_reg_slave.sv
module lin_reg_slave #(
  parameter int         NOM_CLKS    = 2500,
  parameter logic [7:0] ROUTE_A_RST = 8'h00,
  parameter logic [7:0] ROUTE_B_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] id_sel,
  input  logic       rxd,
  output logic       txd,
  output logic [7:0] route_a,
  output logic [7:0] route_b,
  output logic [7:0] err_flags
);

  localparam int BW = $clog2(11 * NOM_CLKS + 1);
  localparam int TW = $clog2((84 * 14 * NOM_CLKS) / 10 + 2);
  localparam logic [BW-1:0] BRK_MIN = BW'((21 * NOM_CLKS) / 2);
  localparam logic [BW-1:0] SYNC_LO = BW'(7 * NOM_CLKS);
  localparam logic [BW-1:0] SYNC_HI = BW'(9 * NOM_CLKS);
  localparam logic [BW-1:0] BIT_LO  = SYNC_LO >> 3;
  localparam logic [BW-1:0] BIT_HI  = SYNC_HI >> 3;
  localparam logic [TW-1:0] TMO_WR  = TW'((64 * 14 * NOM_CLKS) / 10);
  localparam logic [TW-1:0] TMO_RD  = TW'((84 * 14 * NOM_CLKS) / 10);

  typedef enum logic [2:0] {
    S_IDLE, S_BRK, S_DELIM, S_SYNC, S_RXW, S_RXB, S_TXGAP, S_TX
  } st_t;

  st_t           state;
  logic          rx_m, rx_s, rx_p;
  logic [BW-1:0] cnt, bitlen;
  logic [2:0]    nfall;
  logic [3:0]    bidx;
  logic [7:0]    rx_sh, sum, dat_a, dat_b, tx_b;
  logic [8:0]    tx_sh;
  logic [2:0]    byte_n;
  logic [TW-1:0] ftime, tlim;
  logic [4:0]    flg;
  logic [5:0]    wr_id, rd_id;

  wire           fall   = rx_p & ~rx_s;
  wire [BW-1:0]  half   = bitlen >> 1;
  wire [5:0]     rid    = rx_sh[5:0];
  wire           par_ok = (rx_sh[6] == (rid[0] ^ rid[1] ^ rid[2] ^ rid[4])) &&
                          (rx_sh[7] == ~(rid[1] ^ rid[3] ^ rid[4] ^ rid[5]));

  assign err_flags = {3'b000, flg};

  function automatic logic [7:0] cadd(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[7:0] + {7'd0, t[8]};
  endfunction

  always_comb begin
    case (id_sel)
      2'b00:   begin wr_id = 6'h08; rd_id = 6'h27; end
      2'b01:   begin wr_id = 6'h0A; rd_id = 6'h29; end
      default: begin wr_id = 6'h1C; rd_id = 6'h2B; end
    endcase
  end

  always_comb begin
    case (byte_n)
      3'd0:    tx_b = {3'b000, flg};
      3'd1:    tx_b = route_a;
      3'd2:    tx_b = route_b;
      3'd3:    tx_b = 8'hFF;
      default: tx_b = ~sum;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_p <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      rx_p <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitlen  <= BW'(NOM_CLKS);
      nfall   <= '0;
      bidx    <= '0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      sum     <= '0;
      dat_a   <= '0;
      dat_b   <= '0;
      byte_n  <= '0;
      ftime   <= '0;
      tlim    <= TMO_WR;
      flg     <= '0;
      txd     <= 1'b1;
      route_a <= ROUTE_A_RST;
      route_b <= ROUTE_B_RST;
    end else begin
      if (state != S_IDLE) ftime <= ftime + 1'b1;
      if (state != S_IDLE && ftime >= tlim) begin
        flg[0] <= 1'b1;
        txd    <= 1'b1;
        state  <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            txd   <= 1'b1;
            ftime <= '0;
            if (fall) begin
              state <= S_BRK;
              cnt   <= BW'(1);
              tlim  <= TMO_WR;
            end
          end
          S_BRK: begin
            if (rx_s) state <= (cnt >= BRK_MIN) ? S_DELIM : S_IDLE;
            else if (cnt < BRK_MIN) cnt <= cnt + 1'b1;
          end
          S_DELIM: begin
            if (fall) begin
              state <= S_SYNC;
              cnt   <= BW'(1);
              nfall <= '0;
            end
          end
          S_SYNC: begin
            cnt <= cnt + 1'b1;
            if (fall && nfall == 3'd3) begin
              if (cnt < SYNC_LO || cnt > SYNC_HI) begin
                flg[4] <= 1'b1;
                state  <= S_IDLE;
              end else begin
                bitlen <= cnt >> 3;
                byte_n <= '0;
                state  <= S_RXW;
              end
            end else if (cnt > SYNC_HI) begin
              flg[4] <= 1'b1;
              state  <= S_IDLE;
            end else if (fall) begin
              nfall <= nfall + 1'b1;
            end
          end
          S_RXW: begin
            if (fall) begin
              state <= S_RXB;
              cnt   <= half;
              bidx  <= '0;
            end
          end
          S_RXB: begin
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else begin
              cnt  <= bitlen - 1'b1;
              bidx <= bidx + 1'b1;
              if (bidx == 4'd0) begin
                if (rx_s) state <= S_RXW;
              end else if (bidx != 4'd9) begin
                rx_sh <= {rx_s, rx_sh[7:1]};
              end else if (!rx_s) begin
                state <= S_IDLE;
              end else if (byte_n == 3'd0) begin
                if (!par_ok) begin
                  flg[1] <= 1'b1;
                  state  <= S_IDLE;
                end else if (rid == wr_id) begin
                  sum    <= rx_sh;
                  byte_n <= 3'd1;
                  state  <= S_RXW;
                end else if (rid == rd_id) begin
                  sum   <= rx_sh;
                  tlim  <= TMO_RD;
                  cnt   <= half;
                  state <= S_TXGAP;
                end else begin
                  state <= S_IDLE;
                end
              end else if (byte_n != 3'd3) begin
                if (byte_n == 3'd1) dat_a <= rx_sh;
                else                dat_b <= rx_sh;
                sum    <= cadd(sum, rx_sh);
                byte_n <= byte_n + 1'b1;
                state  <= S_RXW;
              end else begin
                if (rx_sh == ~sum) begin
                  route_a <= dat_a;
                  route_b <= dat_b;
                end else begin
                  flg[2] <= 1'b1;
                end
                state <= S_IDLE;
              end
            end
          end
          S_TXGAP: begin
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else begin
              tx_sh  <= {1'b1, tx_b};
              txd    <= 1'b0;
              bidx   <= '0;
              cnt    <= bitlen - 1'b1;
              sum    <= cadd(sum, tx_b);
              byte_n <= byte_n + 1'b1;
              state  <= S_TX;
            end
          end
          S_TX: begin
            if (cnt == half && rx_s != txd) begin
              flg[3] <= 1'b1;
              txd    <= 1'b1;
              state  <= S_IDLE;
            end else if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else if (bidx != 4'd9) begin
              bidx  <= bidx + 1'b1;
              txd   <= tx_sh[0];
              tx_sh <= tx_sh >> 1;
              cnt   <= bitlen - 1'b1;
            end else if (byte_n == 3'd5) begin
              flg   <= '0;
              state <= S_IDLE;
            end else begin
              tx_sh  <= {1'b1, tx_b};
              txd    <= 1'b0;
              bidx   <= '0;
              cnt    <= bitlen - 1'b1;
              sum    <= cadd(sum, tx_b);
              byte_n <= byte_n + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_TXD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_TX) |-> txd); // R9

  AST_ROUTE_ON_CKS: assert property (@(posedge clk) disable iff (!rst_n)
    (route_a != $past(route_a) || route_b != $past(route_b)) |->
      $past(state == S_RXB && byte_n == 3'd3)); // R5

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flg) & ~flg)) |-> ($past(state == S_TX && byte_n == 3'd5) && flg == 5'd0)); // R11

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> (ftime <= tlim)); // R10

  AST_BITLEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RXB || state == S_TX) |-> (bitlen >= BIT_LO && bitlen <= BIT_HI)); // R2

endmodule

// File: tb/tb_lin_reg_slave.sv
`timescale 1ns/1ps
module tb_lin_reg_slave;

  localparam int NB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       mdrv = 1'b1;
  logic       jam = 1'b0;
  logic       txd;
  logic [7:0] route_a, route_b, err_flags;
  wire        bus = mdrv & txd & ~jam;

  int nrun = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  lin_reg_slave #(.NOM_CLKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .id_sel(sel), .rxd(bus),
    .txd(txd), .route_a(route_a), .route_b(route_b), .err_flags(err_flags)
  );

  // {sel, pid, d0, d1, corrupt_cks, exp_route_a, exp_route_b, exp_flags}
  localparam logic [50:0] VEC [8] = '{
    {2'b00, 8'h08, 8'h11, 8'h22, 1'b0, 8'h11, 8'h22, 8'h00},  // R5 R6
    {2'b01, 8'hCA, 8'h5A, 8'hA5, 1'b0, 8'h5A, 8'hA5, 8'h00},  // R4
    {2'b10, 8'h9C, 8'hFF, 8'h01, 1'b0, 8'hFF, 8'h01, 8'h00},  // R6 carry wrap
    {2'b11, 8'h9C, 8'h80, 8'h80, 1'b0, 8'h80, 8'h80, 8'h00},  // R4
    {2'b00, 8'h9C, 8'h33, 8'h44, 1'b0, 8'h80, 8'h80, 8'h00},  // R4 ignored
    {2'b01, 8'h2B, 8'h55, 8'h66, 1'b0, 8'h80, 8'h80, 8'h00},  // R4 ignored
    {2'b10, 8'h9C, 8'h12, 8'h34, 1'b1, 8'h80, 8'h80, 8'h04},  // R7
    {2'b00, 8'h48, 8'h77, 8'h88, 1'b0, 8'h80, 8'h80, 8'h06}   // R3
  };

  function automatic logic [7:0] wadd(input logic [7:0] s, input logic [7:0] b);
    int t;
    t = int'(s) + int'(b);
    if (t > 255) t = t - 255;
    return t[7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tx_bit(input logic v, input int w);
    mdrv = v;
    repeat (w) @(negedge clk);
  endtask

  task automatic tx_byte(input logic [7:0] b, input int w);
    tx_bit(1'b0, w);
    for (int i = 0; i < 8; i++) tx_bit(b[i], w);
    tx_bit(1'b1, w);
  endtask

  task automatic header(input logic [7:0] pid, input int w, input int brk);
    tx_bit(1'b0, brk * NB);
    tx_bit(1'b1, NB);
    tx_byte(8'h55, w);
    tx_byte(pid, w);
  endtask

  task automatic rx_byte(output logic [7:0] b, output bit got, input bit do_jam);
    got = 1'b0;
    b = '0;
    for (int i = 0; i < 40 * NB && !got; i++) begin
      @(negedge clk);
      if (!bus) got = 1'b1;
    end
    if (got) begin
      repeat (NB / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (NB) @(negedge clk);
        b[i] = bus;
      end
      if (do_jam) begin
        repeat (NB / 2) @(negedge clk);
        jam = 1'b1;
        repeat (NB) @(negedge clk);
        jam = 1'b0;
      end else begin
        repeat (NB) @(negedge clk);
      end
    end
  endtask

  task automatic do_read(input logic [7:0] pid, input int jam_idx,
                         output logic [7:0] rb [5], output int n);
    logic [7:0] b;
    bit got;
    n = 0;
    for (int k = 0; k < 5; k++) rb[k] = 8'h00;
    header(pid, NB, 13);
    for (int k = 0; k < 5; k++) begin
      rx_byte(b, got, k == jam_idx);
      if (!got) break;
      rb[k] = b;
      n++;
    end
    tx_bit(1'b1, 3 * NB);
  endtask

  task automatic write_frame(input logic [7:0] pid, input logic [7:0] a, input logic [7:0] b,
                             input bit bad, input int w);
    logic [7:0] c;
    c = ~wadd(wadd(pid, a), b);
    if (bad) c = c ^ 8'h01;
    header(pid, w, 13);
    tx_byte(a, w);
    tx_byte(b, w);
    tx_byte(c, w);
    tx_bit(1'b1, 3 * NB);
  endtask

  task automatic check_read(input logic [7:0] pid, input logic [7:0] e0,
                            input logic [7:0] ea, input logic [7:0] eb);
    logic [7:0] rb [5];
    logic [7:0] exp [5];
    logic [7:0] s;
    int n;
    exp[0] = e0; exp[1] = ea; exp[2] = eb; exp[3] = 8'hFF;
    s = pid;
    for (int k = 0; k < 4; k++) s = wadd(s, exp[k]);
    exp[4] = ~s;
    do_read(pid, -1, rb, n);
    chk(n == 5, "R8 response byte count", 8'(n), 8'd5);
    for (int k = 0; k < 5; k++)
      chk(rb[k] == exp[k], $sformatf("R8 R6 R1 read byte %0d", k), rb[k], exp[k]);
    chk(err_flags == 8'h00, "R11 flags cleared after read", err_flags, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung (R1)");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    logic [7:0] rb [5];
    int n;
    repeat (5) @(negedge clk);
    chk(txd == 1'b1, "R12 txd idle", {7'd0, txd}, 8'h01);
    chk(route_a == 8'h00, "R12 route_a reset", route_a, 8'h00);
    chk(route_b == 8'h00, "R12 route_b reset", route_b, 8'h00);
    chk(err_flags == 8'h00, "R12 flags reset", err_flags, 8'h00);
    rst_n = 1'b1;
    tx_bit(1'b1, 4 * NB);

    for (int v = 0; v < 8; v++) begin
      sel = VEC[v][50:49];
      write_frame(VEC[v][48:41], VEC[v][40:33], VEC[v][32:25], VEC[v][24], NB);
      chk(route_a == VEC[v][23:16], $sformatf("R4 R5 R7 vec %0d route_a", v), route_a, VEC[v][23:16]);
      chk(route_b == VEC[v][15:8],  $sformatf("R4 R5 R7 vec %0d route_b", v), route_b, VEC[v][15:8]);
      chk(err_flags == VEC[v][7:0], $sformatf("R3 R11 vec %0d flags", v), err_flags, VEC[v][7:0]);
    end

    sel = 2'b00;
    check_read(8'hE7, 8'h06, 8'h80, 8'h80);
    check_read(8'hE7, 8'h00, 8'h80, 8'h80);

    header(8'h08, 20, 13);
    tx_bit(1'b1, 4 * NB);
    chk(err_flags == 8'h10, "R2 sync out of tolerance", err_flags, 8'h10);

    header(8'h08, NB, 13);
    tx_byte(8'h01, NB);
    tx_bit(1'b1, 70 * NB);
    chk(err_flags == 8'h11, "R10 frame timeout", err_flags, 8'h11);
    chk(route_a == 8'h80, "R10 route_a kept", route_a, 8'h80);

    do_read(8'hE7, 1, rb, n);
    chk(rb[0] == 8'h11, "R11 status byte before collision", rb[0], 8'h11);
    chk(n == 2, "R9 response stops after collision", 8'(n), 8'd2);
    chk(err_flags == 8'h19, "R9 readback flag", err_flags, 8'h19);
    chk(txd == 1'b1, "R9 txd released", {7'd0, txd}, 8'h01);

    sel = 2'b10;
    check_read(8'h2B, 8'h19, 8'h80, 8'h80);

    write_frame(8'h9C, 8'h3C, 8'hC3, 1'b0, 18);
    chk(route_a == 8'h3C, "R2 R1 slow sync accepted route_a", route_a, 8'h3C);
    chk(route_b == 8'hC3, "R2 R1 slow sync accepted route_b", route_b, 8'hC3);

    header(8'h9C, NB, 8);
    tx_byte(8'h01, NB);
    tx_byte(8'h02, NB);
    tx_byte(~wadd(wadd(8'h9C, 8'h01), 8'h02), NB);
    tx_bit(1'b1, 3 * NB);
    chk(route_a == 8'h3C, "R2 short break ignored", route_a, 8'h3C);
    chk(err_flags == 8'h00, "R2 short break no flag", err_flags, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule